// File: doc/BRIEF.md
# Posted-Write Buffer with Narrow-Write Combining

This block sits in a bridge between a fast upstream initiator and a slower downstream target. Memory and I/O writes from upstream are accepted at one per cycle into an eight-entry queue. The queue then empties towards the downstream port at whatever rate that port acknowledges. Upstream never waits for downstream completion of a write unless the queue is full.

When combining is switched on, a narrow memory write of one or two byte lanes is folded into the youngest queued entry. This needs three things: the write targets the same 32-bit doubleword as that entry, it touches only lanes the entry does not already hold, and the entry is not the one currently offered downstream. I/O writes always get an entry of their own, so program order is kept lane by lane. A read request from upstream is held back until the queue has fully drained. It then goes out on the same downstream port, and its data is handed back to upstream in the cycle of the downstream acknowledge.

Top module: `posted_write_buffer`

## Requirements
- R1: While reset is held and after its release with no traffic, `dn_req` is 0 and `up_ready` is 1 for a presented write.
- R2: A write is accepted in any cycle the queue holds fewer than 8 entries. Once 8 entries are held and none leaves, `up_ready` is 0 for a write.
- R3: Queued entries are offered downstream oldest first, one entry per cycle in which `dn_req` and `dn_ack` are both 1, with `dn_write`=1. `dn_addr` is the write's doubleword address with bits [1:0] zero, and `dn_data`, `dn_be` and `dn_is_io` are as written.
- R4: With `merge_en`=1, a memory write combines into the youngest entry when all of these hold: it has one or two byte enables set, its address bits [31:2] equal the entry's, its enables share no lane with the entry's, and the queue holds at least two entries. The entry's enables become the OR of both, and each byte lane i (bits 8i+7..8i) takes the new data where the new enable bit i is set.
- R5: A write whose enables overlap any lane already enabled in the youngest entry takes a new entry.
- R6: With `merge_en`=0, every write takes its own entry.
- R7: A write with `up_is_io`=1 is never combined, and no write is combined into an entry made by an I/O write.
- R8: A read (`up_write`=0) is not offered downstream while any write is queued. It appears on `dn_req` with `dn_write`=0 in the second cycle after the cycle of the last write's acknowledge, or in the cycle after the request if the queue is already empty. Its `up_ready` equals `dn_ack`, and `up_rdata` equals `dn_rdata` in that cycle.
- R9: While `dn_req` is 1 and `dn_ack` is 0, the next cycle keeps `dn_req` at 1 with `dn_addr`, `dn_data`, `dn_be`, `dn_write` and `dn_is_io` unchanged.
- R10: The entry being offered downstream is never modified: when it is the only entry, a following write to its doubleword takes a new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | Enables combining of narrow memory writes |
| up_valid | input | 1 | Upstream request present |
| up_write | input | 1 | 1 = write, 0 = read |
| up_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| up_addr | input | 32 | Byte address |
| up_data | input | 32 | Write data |
| up_be | input | 4 | Byte enables, bit i for lane i |
| up_ready | output | 1 | Request accepted this cycle |
| up_rdata | output | 32 | Read data, valid with `up_ready` of a read |
| dn_req | output | 1 | Downstream request |
| dn_write | output | 1 | 1 = write, 0 = read |
| dn_is_io | output | 1 | I/O space flag |
| dn_addr | output | 32 | Downstream address |
| dn_data | output | 32 | Downstream write data |
| dn_be | output | 4 | Downstream byte enables |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume that upstream holds a presented request, with all its fields, steady until `up_ready`, and that downstream read data is valid in the acknowledge cycle. Without the first, the read-path hold check on `dn_addr` and the accept-side checks could fire on input churn instead of design faults. The stimulus drives every request from one task that changes inputs only after a falling edge and keeps them until acceptance. It also sweeps all pairs of byte-enable patterns against combining on and off, I/O or memory on each side, and same or different doubleword. In each case a filler entry sits at the head, so the combining decision is isolated from the head-protection rule.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int ADDR_W = 32;
  localparam int LANE_W = $clog2(BE_W);
  localparam int DW_W   = ADDR_W - LANE_W;

  typedef struct packed {
    logic              io;
    logic [DW_W-1:0]   dw;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } pwb_entry_t;
endpackage

// File: rtl/pwb_merge_unit.sv
module pwb_merge_unit
  import pwb_pkg::*;
#(
  parameter int NARROW_LANES = 2
) (
  input  logic              merge_en,
  input  logic              tail_ok,
  input  pwb_entry_t        tail,
  input  pwb_entry_t        wr,
  output logic              hit,
  output pwb_entry_t        merged
);
  localparam int CNT_W = $clog2(BE_W + 1);

  logic [CNT_W-1:0]  lanes_set;
  logic              is_narrow;
  logic              same_dw;
  logic              disjoint;
  logic [DATA_W-1:0] mdata;

  always_comb begin
    lanes_set = '0;
    for (int i = 0; i < BE_W; i++) begin
      lanes_set = lanes_set + CNT_W'(wr.be[i]);
    end
  end

  assign is_narrow = (lanes_set != '0) && (lanes_set <= CNT_W'(NARROW_LANES));
  assign same_dw   = (wr.dw == tail.dw);
  assign disjoint  = ((wr.be & tail.be) == '0);

  assign hit = merge_en && tail_ok && !wr.io && !tail.io &&
               is_narrow && same_dw && disjoint;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign mdata[8*g +: 8] = wr.be[g] ? wr.data[8*g +: 8] : tail.data[8*g +: 8];
  end

  always_comb begin
    merged      = tail;
    merged.be   = tail.be | wr.be;
    merged.data = mdata;
  end
endmodule

// File: rtl/pwb_fifo.sv
module pwb_fifo
  import pwb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  pwb_entry_t push_entry,
  input  logic       mrg,
  input  pwb_entry_t mrg_entry,
  input  logic       pop,
  output pwb_entry_t head,
  output pwb_entry_t tail,
  output logic       tail_ok,
  output logic       full,
  output logic       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  pwb_entry_t    mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] tail_idx;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign tail_idx = (wptr_q == '0) ? LAST : wptr_q - PW'(1);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) begin
      wptr_d = bump(wptr_q);
    end
    if (pop) begin
      rptr_d = bump(rptr_q);
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push || pop) begin
        wptr_q <= wptr_d;
        rptr_q <= rptr_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wptr_q] <= push_entry;
    end else if (mrg) begin
      mem[tail_idx] <= mrg_entry;
    end
  end

  assign head    = mem[rptr_q];
  assign tail    = mem[tail_idx];
  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign tail_ok = (cnt_q >= CW'(2));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  p_head_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mrg |-> (cnt_q > CW'(1)) && !push);
endmodule

// File: rtl/pwb_order_gate.sv
module pwb_order_gate
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic              up_is_io,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [BE_W-1:0]   up_be,
  input  logic              fifo_empty,
  input  pwb_entry_t        head,
  input  logic              dn_ack,
  output logic              pop,
  output logic              rd_done,
  output logic              dn_req,
  output logic              dn_write,
  output logic              dn_is_io,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic [BE_W-1:0]   dn_be
);
  typedef enum logic {GATE_WR = 1'b0, GATE_RD = 1'b1} gate_state_e;

  gate_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      GATE_WR: if (up_valid && !up_write && fifo_empty) st_d = GATE_RD;
      GATE_RD: if (dn_ack) st_d = GATE_WR;
      default: st_d = GATE_WR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= GATE_WR;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    if (st_q == GATE_RD) begin
      dn_req   = 1'b1;
      dn_write = 1'b0;
      dn_is_io = up_is_io;
      dn_addr  = up_addr;
      dn_data  = '0;
      dn_be    = up_be;
    end else begin
      dn_req   = !fifo_empty;
      dn_write = 1'b1;
      dn_is_io = head.io;
      dn_addr  = {head.dw, {LANE_W{1'b0}}};
      dn_data  = head.data;
      dn_be    = head.be;
    end
  end

  assign pop     = (st_q == GATE_WR) && !fifo_empty && dn_ack;
  assign rd_done = (st_q == GATE_RD) && dn_ack;

  p_read_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_write) |-> fifo_empty);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack) |=> dn_req && $stable(dn_addr) && $stable(dn_data) &&
                            $stable(dn_be) && $stable(dn_write) && $stable(dn_is_io));
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer
  import pwb_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int NARROW_LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              merge_en,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic              up_is_io,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  input  logic [BE_W-1:0]   up_be,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_req,
  output logic              dn_write,
  output logic              dn_is_io,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic [BE_W-1:0]   dn_be,
  input  logic              dn_ack,
  input  logic [DATA_W-1:0] dn_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pwb_entry_t wr_entry, head, tail, merged;
  logic       tail_ok, full, empty, hit;
  logic       wr_fire, push, mrg, pop, rd_done;

  assign wr_entry.io   = up_is_io;
  assign wr_entry.dw   = up_addr[ADDR_W-1:LANE_W];
  assign wr_entry.be   = up_be;
  assign wr_entry.data = up_data;

  pwb_merge_unit #(.NARROW_LANES(NARROW_LANES)) u_merge (
    .merge_en (merge_en),
    .tail_ok  (tail_ok),
    .tail     (tail),
    .wr       (wr_entry),
    .hit      (hit),
    .merged   (merged)
  );

  assign up_ready = up_write ? !full : rd_done;
  assign wr_fire  = up_valid && up_write && !full;
  assign push     = wr_fire && !hit;
  assign mrg      = wr_fire && hit;
  assign up_rdata = dn_rdata;

  pwb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push       (push),
    .push_entry (wr_entry),
    .mrg        (mrg),
    .mrg_entry  (merged),
    .pop        (pop),
    .head       (head),
    .tail       (tail),
    .tail_ok    (tail_ok),
    .full       (full),
    .empty      (empty)
  );

  pwb_order_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .up_valid   (up_valid),
    .up_write   (up_write),
    .up_is_io   (up_is_io),
    .up_addr    (up_addr),
    .up_be      (up_be),
    .fifo_empty (empty),
    .head       (head),
    .dn_ack     (dn_ack),
    .pop        (pop),
    .rd_done    (rd_done),
    .dn_req     (dn_req),
    .dn_write   (dn_write),
    .dn_is_io   (dn_is_io),
    .dn_addr    (dn_addr),
    .dn_data    (dn_data),
    .dn_be      (dn_be)
  );

  p_lanes_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrg |-> ((tail.be & up_be) == '0));
  p_merge_gated_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrg |-> merge_en);
  p_io_never_merged_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrg |-> (!up_is_io && !tail.io));
  p_merge_narrow_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrg |-> ($countones(up_be) >= 1 && $countones(up_be) <= NARROW_LANES));
endmodule

// File: tb/test_posted_write_buffer.sv
module test_posted_write_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        merge_en = 1'b0;
  logic        up_valid = 1'b0;
  logic        up_write = 1'b1;
  logic        up_is_io = 1'b0;
  logic [31:0] up_addr = '0;
  logic [31:0] up_data = '0;
  logic [3:0]  up_be = '0;
  logic        up_ready;
  logic [31:0] up_rdata;
  logic        dn_req, dn_write, dn_is_io;
  logic [31:0] dn_addr, dn_data;
  logic [3:0]  dn_be;
  logic        dn_ack = 1'b0;
  logic [31:0] dn_rdata = '0;

  posted_write_buffer i_posted_write_buffer (
    .clk(clk), .rst_n(rst_n), .merge_en(merge_en),
    .up_valid(up_valid), .up_write(up_write), .up_is_io(up_is_io),
    .up_addr(up_addr), .up_data(up_data), .up_be(up_be),
    .up_ready(up_ready), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_write(dn_write), .dn_is_io(dn_is_io),
    .dn_addr(dn_addr), .dn_data(dn_data), .dn_be(dn_be),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ack_en = 1'b0;
  bit ack_slow = 1'b0;
  bit ack_tgl = 1'b0;

  int          obs_n = 0;
  logic [31:0] obs_addr [32];
  logic [31:0] obs_data [32];
  logic [3:0]  obs_be   [32];
  logic        obs_io   [32];
  int          last_wr_cyc = -1;
  int          rd_first = -1;
  int          rd_after = -1;

  logic        hold_pend = 1'b0;
  logic [31:0] hold_addr, hold_data;
  logic [3:0]  hold_be;
  logic        hold_wr, hold_io;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) cyc++;

  // downstream target model
  always @(negedge clk) begin
    #2;
    if (hold_pend) begin
      chk(dn_req && dn_addr == hold_addr && dn_data == hold_data && dn_be == hold_be &&
          dn_write == hold_wr && dn_is_io == hold_io, "R9 request held",
          {dn_addr, dn_data}, {hold_addr, hold_data});
    end
    ack_tgl = ack_slow ? !ack_tgl : 1'b1;
    dn_ack = ack_en && ack_tgl;
    dn_rdata = {dn_addr[15:0], 16'h5A5A};
    hold_pend = dn_req && !dn_ack;
    hold_addr = dn_addr; hold_data = dn_data; hold_be = dn_be;
    hold_wr = dn_write; hold_io = dn_is_io;
    if (dn_req && !dn_write && rd_first < 0) rd_first = cyc;
    if (dn_req && dn_ack) begin
      if (dn_write) begin
        if (obs_n < 32) begin
          obs_addr[obs_n] = dn_addr; obs_data[obs_n] = dn_data;
          obs_be[obs_n] = dn_be; obs_io[obs_n] = dn_is_io;
        end
        obs_n++;
        last_wr_cyc = cyc;
      end else begin
        rd_after = obs_n;
      end
    end
  end

  task automatic put_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input logic io);
    @(negedge clk); #1;
    up_valid = 1'b1; up_write = 1'b1; up_addr = a; up_data = d; up_be = be; up_is_io = io;
    #2;
    while (!up_ready) begin
      @(negedge clk); #3;
    end
    @(posedge clk); #1;
    up_valid = 1'b0;
  endtask

  task automatic get_rd(input logic [31:0] a, output logic [31:0] d, output int req_cyc);
    @(negedge clk); #1;
    req_cyc = cyc;
    up_valid = 1'b1; up_write = 1'b0; up_addr = a; up_be = 4'hF; up_is_io = 1'b0;
    #2;
    while (!up_ready) begin
      @(negedge clk); #3;
    end
    d = up_rdata;
    @(posedge clk); #1;
    up_valid = 1'b0; up_write = 1'b1;
  endtask

  task automatic drain();
    @(negedge clk); #1;
    ack_en = 1'b1;
    do begin
      @(negedge clk); #3;
    end while (dn_req);
    ack_en = 1'b0;
  endtask

  function automatic int ones4(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  function automatic logic [31:0] lane_mix(input logic [31:0] old_d, input logic [31:0] new_d, input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? new_d[8*i +: 8] : old_d[8*i +: 8];
    return r;
  endfunction

  task automatic chk_entry(input int k, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be, input logic io, input string req);
    chk(obs_addr[k] == a && obs_data[k] == d && obs_be[k] == be && obs_io[k] == io, req,
        {obs_addr[k], obs_data[k]}, {a, d});
    chk(obs_be[k] == be && obs_io[k] == io, req, {59'd0, obs_io[k], obs_be[k]}, {59'd0, io, be});
  endtask

  initial begin
    logic [31:0] rd_d;
    int rq;
    repeat (3) @(negedge clk);
    #1;
    chk(dn_req == 1'b0, "R1 no request in reset", {63'd0, dn_req}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    chk(dn_req == 1'b0, "R1 idle after reset", {63'd0, dn_req}, 64'd0);
    chk(up_ready == 1'b1, "R1 ready after reset", {63'd0, up_ready}, 64'd1);

    // sweep: filler at head, then A, then B
    for (int men = 0; men < 2; men++)
      for (int ioa = 0; ioa < 2; ioa++)
        for (int iob = 0; iob < 2; iob++)
          for (int dif = 0; dif < 2; dif++)
            for (int b1 = 1; b1 < 16; b1++)
              for (int b2 = 1; b2 < 16; b2++) begin
                logic [31:0] d1, d2, a2;
                logic [3:0]  be1, be2;
                bit hit;
                be1 = 4'(b1); be2 = 4'(b2);
                d1 = 32'h1122_3344 ^ 32'(b1 * 131 + b2);
                d2 = 32'hA5B6_C7D8 ^ 32'(b2 * 977 + b1);
                a2 = (dif != 0) ? 32'h0000_0044 : 32'h0000_0042;
                hit = (men != 0) && (ioa == 0) && (iob == 0) && (dif == 0) &&
                      (ones4(be2) >= 1) && (ones4(be2) <= 2) && ((be1 & be2) == 4'd0);
                obs_n = 0;
                @(negedge clk); #1;
                merge_en = (men != 0);
                put_wr(32'h0000_0100, 32'hF0F0_F0F0, 4'hF, 1'b0);
                put_wr(32'h0000_0041, d1, be1, ioa[0]);
                put_wr(a2, d2, be2, iob[0]);
                drain();
                if (hit) begin
                  // R4: merged entry
                  chk(obs_n == 2, "R4 merged count", 64'(obs_n), 64'd2);
                  chk_entry(1, 32'h0000_0040, lane_mix(d1, d2, be2), be1 | be2, 1'b0, "R4 merged entry");
                end else begin
                  // R5 R6 R7: separate entries kept in order
                  chk(obs_n == 3, (men == 0) ? "R6 no merge when off" :
                      ((ioa | iob) != 0) ? "R7 io not merged" : "R5 new entry", 64'(obs_n), 64'd3);
                  chk_entry(1, 32'h0000_0040, d1, be1, ioa[0], "R3 order A");
                  chk_entry(2, {a2[31:2], 2'b00}, d2, be2, iob[0], "R3 order B");
                end
                chk_entry(0, 32'h0000_0100, 32'hF0F0_F0F0, 4'hF, 1'b0, "R3 head first");
              end

    // R10: sole entry is being offered, cannot be modified
    obs_n = 0;
    @(negedge clk); #1; merge_en = 1'b1;
    put_wr(32'h0000_0080, 32'h0000_00AA, 4'b0001, 1'b0);
    put_wr(32'h0000_0081, 32'h0000_BB00, 4'b0010, 1'b0);
    put_wr(32'h0000_0082, 32'h00CC_0000, 4'b0100, 1'b0);
    drain();
    chk(obs_n == 2, "R10 head untouched count", 64'(obs_n), 64'd2);
    chk_entry(0, 32'h80, 32'h0000_00AA, 4'b0001, 1'b0, "R10 head entry");
    chk_entry(1, 32'h80, 32'h00CC_BB00, 4'b0110, 1'b0, "R10 later merge");

    // R2: fill to 8, ninth refused
    obs_n = 0; merge_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      put_wr(32'h0000_1000 + 32'(k * 4), 32'hD000_0000 + 32'(k), 4'hF, 1'b0);
    end
    @(negedge clk); #1;
    up_valid = 1'b1; up_write = 1'b1; up_addr = 32'h2000; up_data = 32'h9; up_be = 4'hF;
    #2;
    chk(up_ready == 1'b0, "R2 full refuses write", {63'd0, up_ready}, 64'd0);
    @(posedge clk); #1; up_valid = 1'b0;
    ack_slow = 1'b1;
    drain();
    ack_slow = 1'b0;
    chk(obs_n == 8, "R2 eight held", 64'(obs_n), 64'd8);
    for (int k = 0; k < 8; k++) begin
      chk_entry(k, 32'h0000_1000 + 32'(k * 4), 32'hD000_0000 + 32'(k), 4'hF, 1'b0, "R3 drain order");
    end

    // R8: read behind posted writes
    obs_n = 0; rd_first = -1; rd_after = -1;
    put_wr(32'h3000, 32'h1, 4'hF, 1'b0);
    put_wr(32'h3004, 32'h2, 4'hF, 1'b1);
    put_wr(32'h3008, 32'h3, 4'hF, 1'b0);
    fork
      get_rd(32'h0000_7654, rd_d, rq);
      begin
        repeat (6) @(negedge clk);
        #3;
        chk(rd_first < 0, "R8 read held while queued", 64'(rd_first), 64'hFFFF_FFFF_FFFF_FFFF);
        ack_en = 1'b1;
      end
    join
    ack_en = 1'b0;
    chk(rd_after == 3, "R8 read after all writes", 64'(rd_after), 64'd3);
    chk(rd_first == last_wr_cyc + 2, "R8 read release timing", 64'(rd_first), 64'(last_wr_cyc + 2));
    chk(rd_d == 32'h7654_5A5A, "R8 read data", {32'd0, rd_d}, 64'h7654_5A5A);
    chk_entry(1, 32'h3004, 32'h2, 4'hF, 1'b1, "R3 io kept in order");

    // R8: read with empty queue
    rd_first = -1;
    @(negedge clk); #1; ack_en = 1'b1;
    get_rd(32'h0000_1234, rd_d, rq);
    ack_en = 1'b0;
    chk(rd_first == rq + 1, "R8 empty read timing", 64'(rd_first), 64'(rq + 1));
    chk(rd_d == 32'h1234_5A5A, "R8 empty read data", {32'd0, rd_d}, 64'h1234_5A5A);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule